// File: doc/BRIEF.md
# LPC Slave Receive Interrupt Unit

This block produces the interrupt requests that an LPC host interface raises toward its local processor. Three host channels each report, through a one-cycle strobe, that the host has finished writing their input data register. Channel 3 can also run a sixteen-byte two-way register block. When that mode is on, its receive interrupt waits for the write to the last byte of the block. Three bus condition events are merged into one error interrupt: LPC reset, LPC shutdown and transfer-cycle abort.

Every source sets its own sticky status flag. Firmware clears each flag one at a time through a write-one-to-clear input. Each interrupt output is a registered level: its flag, or for the error line the OR of the three error flags, gated by an enable. Bus cycle decoding and the register file are outside the block and are seen here only as strobes.

Top module: `lpc_rx_irq`

## Requirements
- R1: While reset is asserted and after it is released with no stimulus, all flags (`rx_flag_o`, `err_flag_o`) and both interrupt outputs are 0.
- R2: A pulse on `rx_done_i[0]` or `rx_done_i[1]` sets the matching bit of `rx_flag_o` at the next clock edge. A set flag stays set until it is cleared. Bit 0 is channel 1, bit 1 is channel 2, bit 2 is channel 3.
- R3: A 1 on bit i of `rx_clr_i` clears `rx_flag_o[i]` at the next edge. If a set and a clear reach the same bit in the same cycle, the set wins.
- R4: At each edge, `rx_irq_o[i]` takes the value that `rx_flag_o[i]` takes at that edge, ANDed with `rx_ie_i[i]` as it was sampled at that edge.
- R5: With `blk_mode_i`=1, a pulse on `blk_wr_i` with `blk_idx_i`=15 sets `rx_flag_o[2]`. Writes to indices 0 to 14 leave it unchanged.
- R6: With `blk_mode_i`=1, `rx_done_i[2]` has no effect. With `blk_mode_i`=0, `rx_done_i[2]` sets `rx_flag_o[2]` and block writes have no effect.
- R7: The `ev_lreset_i`, `ev_shutdown_i` and `ev_abort_i` pulses set `err_flag_o` bits 0, 1 and 2 respectively. These flags are sticky. Each is cleared by the same bit of `err_clr_i`, and a set wins over a clear in the same cycle.
- R8: At each edge, `err_irq_o` takes the OR of the three error flags as they are at that edge, ANDed with `err_ie_i` as it was sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_done_i | input | 3 | Data-register write-complete strobes, channels 1 to 3 |
| blk_mode_i | input | 1 | Two-way block mode for channel 3 |
| blk_wr_i | input | 1 | Write strobe into the channel-3 block |
| blk_idx_i | input | 4 | Byte index of the block write |
| rx_ie_i | input | 3 | Receive interrupt enables |
| rx_clr_i | input | 3 | Write-one-to-clear for receive flags |
| ev_lreset_i | input | 1 | LPC reset event pulse |
| ev_shutdown_i | input | 1 | LPC shutdown event pulse |
| ev_abort_i | input | 1 | Transfer abort event pulse |
| err_ie_i | input | 1 | Error interrupt enable |
| err_clr_i | input | 3 | Write-one-to-clear for error flags |
| rx_flag_o | output | 3 | Receive status flags |
| err_flag_o | output | 3 | Error status flags (reset, shutdown, abort) |
| rx_irq_o | output | 3 | Receive interrupt lines |
| err_irq_o | output | 1 | Error interrupt line |

## Verification
The hardest case to reach from the ports is the boundary of channel 3 in block mode. A write to byte 14 must leave the flag clear, while a write to byte 15 must set it. At the same time the plain strobe must be ignored in that mode and obeyed outside it. To reach this, the bench first clears the flag. It then walks every block index in both modes, with and without a simultaneous plain strobe, and checks after each step that the flag sits exactly where the index and the mode place it. Set-against-clear collisions are covered by exhaustive sweeps of strobe, clear and enable patterns for the receive flags and for the error flags.

// File: rtl/lpc_rx_irq_pkg.sv
package lpc_rx_irq_pkg;
  localparam int unsigned NUM_RX    = 3;
  localparam int unsigned NUM_ERR   = 3;
  localparam int unsigned CH3_BIT   = 2;
  localparam int unsigned BLK_BYTES = 16;
  localparam int unsigned BLK_IDX_W = $clog2(BLK_BYTES);

  // Positions of the error sources inside the error flag vector.
  typedef enum logic [1:0] {
    ERR_LRESET   = 2'd0,
    ERR_SHUTDOWN = 2'd1,
    ERR_ABORT    = 2'd2
  } err_src_e;
endpackage

// File: rtl/lpc_rst_sync.sv
module lpc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/lpc_flag_bank.sv
module lpc_flag_bank #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] d_o,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] flag_d;
  logic [WIDTH-1:0] flag_q;
  logic [WIDTH-1:0] flag_en;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      flag_en[i] = set_i[i] | clr_i[i];
      flag_d[i]  = set_i[i] | (flag_q[i] & ~clr_i[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q[i] <= 1'b0;
      else if (flag_en[i]) flag_q[i] <= flag_d[i];
    end
  end

  assign d_o = flag_d;
  assign q_o = flag_q;

  // R2 and R7: a strobe leaves its flag set
  assert_flag_set_R2_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q_o & $past(set_i)) == $past(set_i)));

  // R3 and R7: untouched flags hold their value
  assert_flag_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((q_o ^ $past(q_o)) & ~$past(set_i | clr_i)) == '0));

  // R3: a clear without a set empties the flag
  assert_flag_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/lpc_ch3_src.sv
module lpc_ch3_src #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned LAST  = 15
) (
  input  logic             blk_mode_i,
  input  logic             plain_i,
  input  logic             blk_wr_i,
  input  logic [IDX_W-1:0] blk_idx_i,
  output logic             set_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LAST);

  logic blk_last;

  always_comb begin
    blk_last = blk_wr_i && (blk_idx_i == LAST_IDX);
    set_o    = blk_mode_i ? blk_last : plain_i;
  end
endmodule

// File: rtl/lpc_irq_gate.sv
module lpc_irq_gate #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned OUT_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] flag_d_i,
  input  logic [WIDTH-1:0] ie_i,
  output logic [OUT_W-1:0] irq_o
);
  logic [WIDTH-1:0] gated;
  logic [OUT_W-1:0] irq_d;
  logic [OUT_W-1:0] irq_q;
  logic [OUT_W-1:0] irq_en;

  always_comb begin
    gated = flag_d_i & ie_i;
  end

  if (OUT_W == 1) begin : g_merge
    always_comb begin
      irq_d = |gated;
    end
  end else begin : g_lane
    always_comb begin
      irq_d = gated;
    end
  end

  always_comb begin
    irq_en = irq_d ^ irq_q;
  end

  for (genvar i = 0; i < OUT_W; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         irq_q[i] <= 1'b0;
      else if (irq_en[i]) irq_q[i] <= irq_d[i];
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/lpc_rx_irq.sv
module lpc_rx_irq
  import lpc_rx_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] rx_done_i,
  input  logic       blk_mode_i,
  input  logic       blk_wr_i,
  input  logic [3:0] blk_idx_i,
  input  logic [2:0] rx_ie_i,
  input  logic [2:0] rx_clr_i,
  input  logic       ev_lreset_i,
  input  logic       ev_shutdown_i,
  input  logic       ev_abort_i,
  input  logic       err_ie_i,
  input  logic [2:0] err_clr_i,
  output logic [2:0] rx_flag_o,
  output logic [2:0] err_flag_o,
  output logic [2:0] rx_irq_o,
  output logic       err_irq_o
);
  localparam logic [BLK_IDX_W-1:0] LAST_IDX = BLK_IDX_W'(BLK_BYTES - 1);

  logic               rst_sync_n;
  logic               ch3_set;
  logic [NUM_RX-1:0]  rx_set;
  logic [NUM_RX-1:0]  rx_flag_d;
  logic [NUM_ERR-1:0] err_set;
  logic [NUM_ERR-1:0] err_flag_d;
  logic [NUM_ERR-1:0] err_ie_vec;

  lpc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  lpc_ch3_src #(.IDX_W(BLK_IDX_W), .LAST(BLK_BYTES - 1)) u_ch3_src (
    .blk_mode_i (blk_mode_i),
    .plain_i    (rx_done_i[CH3_BIT]),
    .blk_wr_i   (blk_wr_i),
    .blk_idx_i  (blk_idx_i),
    .set_o      (ch3_set)
  );

  always_comb begin
    rx_set                       = rx_done_i;
    rx_set[CH3_BIT]              = ch3_set;
    err_set                      = '0;
    err_set[ERR_LRESET]          = ev_lreset_i;
    err_set[ERR_SHUTDOWN]        = ev_shutdown_i;
    err_set[ERR_ABORT]           = ev_abort_i;
    err_ie_vec                   = {NUM_ERR{err_ie_i}};
  end

  lpc_flag_bank #(.WIDTH(NUM_RX)) u_rx_flags (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set_i (rx_set),
    .clr_i (rx_clr_i),
    .d_o   (rx_flag_d),
    .q_o   (rx_flag_o)
  );

  lpc_flag_bank #(.WIDTH(NUM_ERR)) u_err_flags (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set_i (err_set),
    .clr_i (err_clr_i),
    .d_o   (err_flag_d),
    .q_o   (err_flag_o)
  );

  lpc_irq_gate #(.WIDTH(NUM_RX), .OUT_W(NUM_RX)) u_rx_gate (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .flag_d_i (rx_flag_d),
    .ie_i     (rx_ie_i),
    .irq_o    (rx_irq_o)
  );

  lpc_irq_gate #(.WIDTH(NUM_ERR), .OUT_W(1)) u_err_gate (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .flag_d_i (err_flag_d),
    .ie_i     (err_ie_vec),
    .irq_o    (err_irq_o)
  );

  // R4: no receive interrupt without its flag
  assert_irq_needs_flag_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((rx_irq_o & ~rx_flag_o) == '0));

  // R8: error interrupt only with some error flag set
  assert_err_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_irq_o |-> (err_flag_o != '0));

  // R5: final block byte raises the channel-3 flag
  assert_blk_last_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (blk_mode_i && blk_wr_i && blk_idx_i == LAST_IDX) |=> rx_flag_o[CH3_BIT]);

  // R5: earlier block bytes do not raise it
  assert_blk_partial_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (blk_mode_i && blk_wr_i && blk_idx_i != LAST_IDX && !rx_flag_o[CH3_BIT])
      |=> !rx_flag_o[CH3_BIT]);

  // R6: plain strobe ignored in block mode
  assert_plain_ignored_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (blk_mode_i && rx_done_i[CH3_BIT] && !blk_wr_i && !rx_flag_o[CH3_BIT])
      |=> !rx_flag_o[CH3_BIT]);

  // R1: everything quiet while held in reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_sync_n |-> (rx_flag_o == '0 && err_flag_o == '0 && rx_irq_o == '0 && !err_irq_o));
endmodule

// File: tb/lpc_rx_irq_tb.sv
module lpc_rx_irq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] rx_done_i = '0;
  logic       blk_mode_i = 1'b0;
  logic       blk_wr_i = 1'b0;
  logic [3:0] blk_idx_i = '0;
  logic [2:0] rx_ie_i = '0;
  logic [2:0] rx_clr_i = '0;
  logic       ev_lreset_i = 1'b0;
  logic       ev_shutdown_i = 1'b0;
  logic       ev_abort_i = 1'b0;
  logic       err_ie_i = 1'b0;
  logic [2:0] err_clr_i = '0;
  logic [2:0] rx_flag_o;
  logic [2:0] err_flag_o;
  logic [2:0] rx_irq_o;
  logic       err_irq_o;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  logic [2:0] m_rx = '0;
  logic [2:0] m_rx_irq = '0;
  logic [2:0] m_err = '0;
  logic       m_err_irq = 1'b0;

  always #10 clk = ~clk;

  lpc_rx_irq u_dut (
    .clk(clk), .rst_n(rst_n), .rx_done_i(rx_done_i), .blk_mode_i(blk_mode_i),
    .blk_wr_i(blk_wr_i), .blk_idx_i(blk_idx_i), .rx_ie_i(rx_ie_i), .rx_clr_i(rx_clr_i),
    .ev_lreset_i(ev_lreset_i), .ev_shutdown_i(ev_shutdown_i), .ev_abort_i(ev_abort_i),
    .err_ie_i(err_ie_i), .err_clr_i(err_clr_i), .rx_flag_o(rx_flag_o),
    .err_flag_o(err_flag_o), .rx_irq_o(rx_irq_o), .err_irq_o(err_irq_o)
  );

  task automatic check(input logic [2:0] act, input logic [2:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Advance the model by one edge from the current inputs, clock, then compare.
  task automatic step(input string rx_tag);
    logic       s3;
    logic [2:0] ev;
    s3 = blk_mode_i ? (blk_wr_i && blk_idx_i == 4'd15) : rx_done_i[2];
    ev = {ev_abort_i, ev_shutdown_i, ev_lreset_i};
    m_rx      = {s3, rx_done_i[1:0]} | (m_rx & ~rx_clr_i);
    m_rx_irq  = m_rx & rx_ie_i;
    m_err     = ev | (m_err & ~err_clr_i);
    m_err_irq = (|m_err) & err_ie_i;
    @(posedge clk);
    @(negedge clk);
    check(rx_flag_o, m_rx, rx_tag);
    check(rx_irq_o, m_rx_irq, "R4 rx_irq");
    check(err_flag_o, m_err, "R7 err_flag");
    check({2'b00, err_irq_o}, {2'b00, m_err_irq}, "R8 err_irq");
  endtask

  task automatic idle_inputs;
    rx_done_i = '0; blk_wr_i = 1'b0; blk_idx_i = '0; rx_clr_i = '0;
    ev_lreset_i = 1'b0; ev_shutdown_i = 1'b0; ev_abort_i = 1'b0; err_clr_i = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    // R1: reset state, during and after release
    repeat (3) @(negedge clk);
    check(rx_flag_o, 3'b000, "R1 rx_flag in reset");
    check(err_flag_o, 3'b000, "R1 err_flag in reset");
    check({err_irq_o, rx_irq_o}, '0, "R1 irqs in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(rx_flag_o, 3'b000, "R1 rx_flag after release");
    check({err_irq_o, rx_irq_o}, '0, "R1 irqs after release");

    // R2/R3/R4: exhaustive strobe x clear x enable sweep, plain mode
    for (int v = 0; v < 512; v++) begin
      rx_done_i = v[2:0];
      rx_clr_i  = v[5:3];
      rx_ie_i   = v[8:6];
      step("R2/R3 rx_flag");
    end
    idle_inputs();

    // R5/R6: every block index, both modes, with and without plain strobe
    rx_ie_i = 3'b111;
    for (int m = 0; m < 2; m++) begin
      for (int idx = 0; idx < 16; idx++) begin
        for (int p = 0; p < 2; p++) begin
          idle_inputs();
          blk_mode_i = m[0];
          rx_clr_i = 3'b111;
          step("R3 clear before block");
          idle_inputs();
          blk_wr_i = 1'b1;
          blk_idx_i = idx[3:0];
          rx_done_i[2] = p[0];
          if (m == 1) step("R5/R6 block mode ch3");
          else        step("R6 plain mode ch3");
        end
      end
    end
    idle_inputs();
    blk_mode_i = 1'b0;

    // R7/R8: exhaustive event x clear x enable sweep
    for (int v = 0; v < 128; v++) begin
      ev_lreset_i   = v[0];
      ev_shutdown_i = v[1];
      ev_abort_i    = v[2];
      err_clr_i     = v[5:3];
      err_ie_i      = v[6];
      step("R2/R3 rx_flag hold");
    end
    idle_inputs();
    err_ie_i = 1'b1;
    step("R3 rx_flag idle");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule